// File: doc/BRIEF.md
# Key-Protected Reset Control Register

This block is one 32-bit register in a system control space. It answers word reads and writes on a plain register bus that has an address, a write enable, write data and read data. A write is accepted only when its upper halfword holds a fixed unlock value. Any other write is dropped as a whole, so a stray or corrupted store cannot change the register or start a reset.

The register stores a 3-bit priority-grouping field. A keyed write can also request one of two resets. The first is a full system reset. Its request line is held high until the external reset controller acknowledges it. The second resets only the processor core and appears as a one-cycle pulse. Software keeps the grouping field unchanged by writing back the value it last read, together with the key and the request bit.

The register is decoded at one byte address, 0xE000ED0C. This is offset 0x0C inside a control block at 0xE000ED00, which is itself 0xD00 above the system control space base. Every other address is ignored.

Top module: `key_reset_ctrl`

## Requirements
- R1: While the synchronous reset `rst` is high at a clock edge, the grouping field returns to 0, and after that edge `sys_rst_req` and `core_rst_pulse` are 0.
- R2: A read at 0xE000ED0C returns, with no added cycle of latency, 0xFA05 in bits 31:16, 0 in bit 15, the grouping field in bits 10:8 and 0 in every other bit. The reset request bits 2 and 0 always read as 0.
- R3: When the address is not 0xE000ED0C, the read data is 0 and a write changes nothing: the grouping field is unchanged and no reset is requested.
- R4: A write to 0xE000ED0C whose bits 31:16 differ from 0x05FA has no effect on the grouping field or on either reset output.
- R5: A keyed write (key 0x05FA in bits 31:16) loads the grouping field from write data bits 10:8. The new value can be read in the cycle after the write edge.
- R6: A keyed write with bit 2 set raises `sys_rst_req` after that clock edge. The request stays high at every following edge until `sys_rst_ack` is seen high at an edge.
- R7: When `sys_rst_ack` is high at an edge, `sys_rst_req` is low after that edge. The exception is a keyed write with bit 2 set at the same edge: the new request wins and the line stays high.
- R8: A keyed write with bit 0 set and bit 2 clear makes `core_rst_pulse` high for exactly the one cycle after the write edge.
- R9: A keyed write with both bit 2 and bit 0 set raises only `sys_rst_req`. `core_rst_pulse` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 32 | Byte address of the access |
| bus_wen | input | 1 | Write enable for this cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| sys_rst_ack | input | 1 | Acknowledge from the reset controller |
| sys_rst_req | output | 1 | System reset request, held until acknowledged |
| core_rst_pulse | output | 1 | One-cycle request for a core-only reset |

## Verification
Random traffic mixes writes to the matching address with writes to nearby and unrelated addresses. The upper halfword is either the correct key or a random value. The two request bits and the acknowledge line are drawn independently. These patterns separate the address decode from the key check, and the key check from the field update. Directed cases then cover the exact corners: a key that is wrong by one bit, a request and an acknowledge at the same edge, both request bits set together, and a write-back that keeps the grouping field. These cases show whether the request priority and the hold-until-acknowledge rule are both right.

// File: rtl/key_reset_pkg.sv
package key_reset_pkg;
   localparam int unsigned BUS_W       = 32;
   localparam int unsigned KEY_W       = 16;
   localparam logic [31:0] SPACE_BASE  = 32'hE000_E000;
   localparam logic [31:0] BLOCK_OFS   = 32'h0000_0D00;
   localparam logic [31:0] REG_OFS     = 32'h0000_000C;
   localparam logic [31:0] REG_ADDR    = SPACE_BASE + BLOCK_OFS + REG_OFS;
   localparam logic [15:0] WRITE_KEY   = 16'h05FA;
   localparam logic [15:0] READ_KEY    = 16'hFA05;
   localparam int unsigned SYS_BIT     = 2;
   localparam int unsigned CORE_BIT    = 0;
   localparam int unsigned GRP_LSB     = 8;
endpackage

// File: rtl/key_reset_decode.sv
module key_reset_decode
   import key_reset_pkg::*;
#(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned DATA_W = 32,
   parameter logic [ADDR_W-1:0] MATCH_ADDR = REG_ADDR[ADDR_W-1:0],
   parameter logic [KEY_W-1:0]  KEY_VAL    = WRITE_KEY
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              wen,
   input  logic [DATA_W-1:0] wdata,
   output logic              hit,
   output logic              keyed_wr
);
   localparam int unsigned KEY_LSB = DATA_W - KEY_W;

   if (DATA_W < KEY_W + 16) begin : g_chk_width
      $error("data width too small for key field");
   end

   logic key_ok;

   always_comb begin
      hit      = (addr == MATCH_ADDR);
      key_ok   = (wdata[DATA_W-1:KEY_LSB] == KEY_VAL);
      keyed_wr = wen && hit && key_ok;
   end
endmodule

// File: rtl/key_reset_fields.sv
module key_reset_fields
   import key_reset_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned GRP_W  = 3
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wen,
   input  logic              keyed_wr,
   input  logic [DATA_W-1:0] wdata,
   output logic [GRP_W-1:0]  grp_q
);
   localparam int unsigned GRP_MSB = GRP_LSB + GRP_W - 1;

   if (GRP_MSB >= 15) begin : g_chk_grp
      $error("grouping field overlaps upper bits");
   end

   always_ff @(posedge clk) begin
      if (rst)           grp_q <= '0;
      else if (keyed_wr) grp_q <= wdata[GRP_MSB:GRP_LSB];
   end

   // R4
   grp_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (wen && !keyed_wr) |=> $stable(grp_q));

   // R5
   grp_load_chk: assert property (@(posedge clk) disable iff (rst)
      keyed_wr |=> (grp_q == $past(wdata[GRP_MSB:GRP_LSB])));
endmodule

// File: rtl/key_reset_req.sv
module key_reset_req #(
   parameter bit LOCAL_EN = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic keyed_wr,
   input  logic sys_bit,
   input  logic core_bit,
   input  logic ack,
   output logic sys_req,
   output logic core_pulse
);
   logic sys_set;
   assign sys_set = keyed_wr && sys_bit;

   always_ff @(posedge clk) begin
      if (rst)          sys_req <= 1'b0;
      else if (sys_set) sys_req <= 1'b1;
      else if (ack)     sys_req <= 1'b0;
   end

   if (LOCAL_EN) begin : g_local
      always_ff @(posedge clk) begin
         if (rst) core_pulse <= 1'b0;
         else     core_pulse <= keyed_wr && core_bit && !sys_bit;
      end
   end else begin : g_no_local
      assign core_pulse = 1'b0;
   end

   // R6
   sys_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (sys_req && !ack) |=> sys_req);

   // R7
   sys_ack_chk: assert property (@(posedge clk) disable iff (rst)
      (ack && !sys_set) |=> !sys_req);

   // R6
   sys_cause_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(sys_req) |-> $past(sys_set));

   // R9
   core_excl_chk: assert property (@(posedge clk) disable iff (rst)
      sys_set |=> !core_pulse);
endmodule

// File: rtl/key_reset_ctrl.sv
module key_reset_ctrl
   import key_reset_pkg::*;
#(
   parameter int unsigned GRP_W    = 3,
   parameter bit          LOCAL_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [BUS_W-1:0]  bus_addr,
   input  logic              bus_wen,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   input  logic              sys_rst_ack,
   output logic              sys_rst_req,
   output logic              core_rst_pulse
);
   localparam int unsigned GRP_MSB = GRP_LSB + GRP_W - 1;

   logic             hit;
   logic             keyed_wr;
   logic [GRP_W-1:0] grp_q;

   key_reset_decode #(.ADDR_W(BUS_W), .DATA_W(BUS_W)) i_decode (
      .addr(bus_addr), .wen(bus_wen), .wdata(bus_wdata),
      .hit(hit), .keyed_wr(keyed_wr));

   key_reset_fields #(.DATA_W(BUS_W), .GRP_W(GRP_W)) i_fields (
      .clk(clk), .rst(rst), .wen(bus_wen), .keyed_wr(keyed_wr),
      .wdata(bus_wdata), .grp_q(grp_q));

   key_reset_req #(.LOCAL_EN(LOCAL_EN)) i_req (
      .clk(clk), .rst(rst), .keyed_wr(keyed_wr),
      .sys_bit(bus_wdata[SYS_BIT]), .core_bit(bus_wdata[CORE_BIT]),
      .ack(sys_rst_ack), .sys_req(sys_rst_req), .core_pulse(core_rst_pulse));

   always_comb begin
      bus_rdata = '0;
      if (hit) begin
         bus_rdata[BUS_W-1:BUS_W-KEY_W] = READ_KEY;
         bus_rdata[GRP_MSB:GRP_LSB]     = grp_q;
      end
   end

   // R3
   miss_zero_chk: assert property (@(posedge clk) disable iff (rst)
      !hit |-> (bus_rdata == '0));

   // R2
   req_bits_zero_chk: assert property (@(posedge clk) disable iff (rst)
      (bus_rdata[SYS_BIT] == 1'b0) && (bus_rdata[CORE_BIT] == 1'b0));
endmodule

// File: tb/test_key_reset_ctrl.sv
module test_key_reset_ctrl;
   localparam logic [31:0] RA = 32'hE000_ED0C;

   logic        clk = 1'b0;
   logic        rst;
   logic [31:0] bus_addr;
   logic        bus_wen;
   logic [31:0] bus_wdata;
   logic [31:0] bus_rdata;
   logic        sys_rst_ack;
   logic        sys_rst_req;
   logic        core_rst_pulse;

   int checks = 0;
   int errors = 0;

   logic [2:0] m_grp;
   logic       m_sys;
   logic       m_core;

   always #4 clk = ~clk;

   key_reset_ctrl i_key_reset_ctrl (
      .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wen(bus_wen),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .sys_rst_ack(sys_rst_ack), .sys_rst_req(sys_rst_req),
      .core_rst_pulse(core_rst_pulse));

   function automatic logic [31:0] exp_rd(logic [31:0] a, logic [2:0] g);
      return (a == RA) ? {16'hFA05, 5'b0, g, 8'h00} : 32'h0;
   endfunction

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // applies one cycle of stimulus and advances the model
   task automatic cycle(logic [31:0] a, logic w, logic [31:0] d, logic k);
      logic keyed;
      @(negedge clk);
      bus_addr = a; bus_wen = w; bus_wdata = d; sys_rst_ack = k;
      keyed = w && (a == RA) && (d[31:16] == 16'h05FA);
      @(posedge clk);
      if (keyed) m_grp = d[10:8];
      m_core = keyed && d[0] && !d[2];
      if (keyed && d[2]) m_sys = 1'b1;
      else if (k)        m_sys = 1'b0;
      #1;
   endtask

   task automatic check_all(string tsys, string tcore, string trd);
      check(tsys, {31'b0, sys_rst_req}, {31'b0, m_sys});
      check(tcore, {31'b0, core_rst_pulse}, {31'b0, m_core});
      check(trd, bus_rdata, exp_rd(bus_addr, m_grp));
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd2718));
      rst = 1'b1; bus_addr = RA; bus_wen = 1'b0; bus_wdata = '0; sys_rst_ack = 1'b0;
      m_grp = '0; m_sys = 1'b0; m_core = 1'b0;
      repeat (3) @(posedge clk);
      #1;
      check("R1", {31'b0, sys_rst_req}, 32'h0);
      check("R1", {31'b0, core_rst_pulse}, 32'h0);
      check("R1", bus_rdata, 32'hFA05_0000);
      @(negedge clk); rst = 1'b0;

      // R5: keyed load of grouping field
      cycle(RA, 1'b1, 32'h05FA_0500, 1'b0);
      check("R5", bus_rdata, 32'hFA05_0500);
      // R4: key off by one bit
      cycle(RA, 1'b1, 32'h05FB_0304, 1'b0);
      check_all("R4", "R4", "R4");
      // R3: wrong address, correct key
      cycle(RA + 32'd4, 1'b1, 32'h05FA_0705, 1'b0);
      check("R3", bus_rdata, 32'h0);
      check_all("R3", "R3", "R3");
      // R8: local pulse for one cycle only
      cycle(RA, 1'b1, 32'h05FA_0501, 1'b0);
      check("R8", {31'b0, core_rst_pulse}, 32'h1);
      cycle(RA, 1'b0, 32'h0, 1'b0);
      check("R8", {31'b0, core_rst_pulse}, 32'h0);
      // R9: both request bits, grouping kept by write-back
      cycle(RA, 1'b1, 32'h05FA_0505, 1'b0);
      check("R9", {31'b0, core_rst_pulse}, 32'h0);
      check("R6", {31'b0, sys_rst_req}, 32'h1);
      check("R2", bus_rdata, 32'hFA05_0500);
      // R6: holds without ack
      repeat (3) begin
         cycle(RA, 1'b0, 32'h0, 1'b0);
         check("R6", {31'b0, sys_rst_req}, 32'h1);
      end
      // R7: ack together with new request keeps it
      cycle(RA, 1'b1, 32'h05FA_0504, 1'b1);
      check("R7", {31'b0, sys_rst_req}, 32'h1);
      // R7: plain ack clears
      cycle(RA, 1'b0, 32'h0, 1'b1);
      check("R7", {31'b0, sys_rst_req}, 32'h0);

      // random traffic against the model
      for (int i = 0; i < 400; i++) begin
         logic [31:0] a, d;
         logic        w, k;
         case ($urandom % 4)
            0:       a = RA + ((($urandom % 3) + 1) << 2);
            1:       a = $urandom;
            default: a = RA;
         endcase
         d = $urandom;
         if ($urandom % 5 < 3) d[31:16] = 16'h05FA;
         w = ($urandom % 4) != 0;
         k = ($urandom % 3) == 0;
         cycle(a, w, d, k);
         check_all("R6", "R8", "R2");
      end

      // R1: reset while a request is pending
      cycle(RA, 1'b1, 32'h05FA_0604, 1'b0);
      @(negedge clk); rst = 1'b1;
      @(posedge clk); #1;
      check("R1", {31'b0, sys_rst_req}, 32'h0);
      check("R1", bus_rdata, 32'hFA05_0000);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule